// File: doc/BRIEF.md
# Multicore Debug Halt Cross-Trigger Network

This block connects the debug-mode state of a group of processor cores, so that a halt on one core can be carried to the other cores. It offers two ways to carry a halt. A break chain sends a one-cycle break request to every other core that accepts one, and that request forces the receiving core into debug mode. A run-stall path freezes the receiving cores without placing them in debug mode. A receiving core's stall is lifted as soon as the halting core leaves debug mode. It is also lifted for as long as the stalled core is in debug mode itself.

A third network carries trace-capture triggers between cores. It uses the same fan-out pattern and the same enables as the break chain, but it has no effect on halting or stalling.

Each core owns a four-bit enable register, and a small register bus writes and reads these registers. A write either stores the raw bits or applies one of three presets. Debug software clears the enables of a core before it single-steps or resumes that core, which isolates the core from the others. Writing the saved value back afterwards reconnects the core.

Top module: `dxt_xtrig_net`

## Requirements
- R1: After synchronous reset, every core's enable register reads 0, and the break, stall and trace outputs are all 0.
- R2: A raw write (op 0) stores `cfg_wr_data` into the addressed core's register. Bit 0 is break-in accept, bit 1 is break-out drive, bit 2 is stall-in accept and bit 3 is debug-mode drive. `cfg_rd_data` returns the register selected by `cfg_rd_core` in the same cycle.
- R3: Preset writes ignore `cfg_wr_data`. Op 1 writes 4'b0000, op 2 (break chain) writes 4'b0011 and op 3 (run-stall) writes 4'b1100.
- R4: Core i's `core_dbg_i` can rise while core i has break-out drive set. On the clock edge that first samples it high, `core_brk_o[j]` goes to 1 for one cycle on every other core j that has break-in accept set and is not in debug mode.
- R5: A core's own debug entry never produces a break, stall or trace event on that same core.
- R6: A core whose `core_dbg_i` is high when the request is formed receives no break pulse.
- R7: A core leaving debug mode produces no break pulse on any core.
- R8: `core_stall_o[j]` is high in the same cycle, with no register on the path, when all of the following hold: core j has stall-in accept set, core j is out of debug mode, and some other core with debug-mode drive set is in debug mode. The stall drops as soon as no such core remains in debug mode.
- R9: A core that is itself in debug mode never has its stall asserted.
- R10: `core_trig_o[j]` is the registered OR of `core_trig_i[i]` over every other core i with break-out drive set, gated by core j's break-in accept. It appears one cycle after the trigger.
- R11: Trace triggers never cause a break pulse or a stall.
- R12: Clearing a core's register isolates it: its debug entry breaks no other core. Writing the saved value back restores propagation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_core | input | CW | Core whose register is written |
| cfg_wr_op | input | 2 | 0 raw, 1 none, 2 break chain, 3 run-stall |
| cfg_wr_data | input | 4 | Raw enable value |
| cfg_rd_core | input | CW | Core whose register is read |
| cfg_rd_data | output | 4 | Enable value of the selected core |
| core_dbg_i | input | NCORE | Per-core debug-mode level |
| core_trig_i | input | NCORE | Per-core trace trigger out |
| core_brk_o | output | NCORE | Registered break request to each core |
| core_stall_o | output | NCORE | Run-stall to each core |
| core_trig_o | output | NCORE | Registered trace trigger into each core |

## Verification
Stall and readback outputs have no register on their path, so the bench compares them a nanosecond after it drives the inputs, before the next edge. Break and trace outputs are due one edge after the inputs that cause them. The bench forms its expectations from the pre-edge debug, previous-debug and enable state, and then samples just after that edge. Register writes take effect at that same edge, so the bench updates its enable model only after it has formed the pre-edge expectations. Directed cases cover presets, masking, release, isolation and restore. They are followed by seeded random debug, trigger and write traffic.

// File: rtl/dxt_pkg.sv
package dxt_pkg;

    localparam int EN_W = 4;

    typedef enum logic [1:0] {
        OP_RAW      = 2'd0,
        OP_NONE     = 2'd1,
        OP_BRKCHAIN = 2'd2,
        OP_RUNSTALL = 2'd3
    } dxt_op_e;

    // bit 0 = break-in accept, bit 3 = debug-mode drive
    typedef struct packed {
        logic dmo;
        logic rsi;
        logic bo;
        logic bi;
    } dxt_en_t;

    function automatic dxt_en_t dxt_apply_op(input dxt_op_e op, input logic [EN_W-1:0] raw);
        dxt_en_t r;
        case (op)
            OP_RAW:      r = dxt_en_t'(raw);
            OP_NONE:     r = '0;
            OP_BRKCHAIN: r = '{dmo: 1'b0, rsi: 1'b0, bo: 1'b1, bi: 1'b1};
            OP_RUNSTALL: r = '{dmo: 1'b1, rsi: 1'b1, bo: 1'b0, bi: 1'b0};
            default:     r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dxt_cfg_regs.sv
module dxt_cfg_regs
    import dxt_pkg::*;
#(
    parameter  int NCORE = 4,
    localparam int CW    = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [CW-1:0]       wr_core,
    input  dxt_op_e             wr_op,
    input  logic [EN_W-1:0]     wr_data,
    input  logic [CW-1:0]       rd_core,
    output logic [EN_W-1:0]     rd_data,
    output logic [NCORE-1:0]    bi_v,
    output logic [NCORE-1:0]    bo_v,
    output logic [NCORE-1:0]    rsi_v,
    output logic [NCORE-1:0]    dmo_v
);

    dxt_en_t cfg_q [NCORE];
    dxt_en_t wr_val;

    assign wr_val = dxt_apply_op(wr_op, wr_data);

    for (genvar j = 0; j < NCORE; j++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[j] <= '0;
            else if (wr_en && (wr_core == CW'(j)))
                cfg_q[j] <= wr_val;
        end
        assign bi_v[j]  = cfg_q[j].bi;
        assign bo_v[j]  = cfg_q[j].bo;
        assign rsi_v[j] = cfg_q[j].rsi;
        assign dmo_v[j] = cfg_q[j].dmo;

        AST_RESET_ISOLATED: assert property (@(posedge clk)
            $past(rst) |-> (cfg_q[j] == '0)); // R1
    end

    always_comb begin
        rd_data = '0;
        for (int j = 0; j < NCORE; j++)
            if (rd_core == CW'(j))
                rd_data = cfg_q[j];
    end

endmodule

// File: rtl/dxt_fan.sv
module dxt_fan #(
    parameter int NCORE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCORE-1:0] src_i,
    input  logic [NCORE-1:0] accept_i,
    output logic [NCORE-1:0] out_o
);

    logic [NCORE-1:0] nxt;

    for (genvar j = 0; j < NCORE; j++) begin : g_dst
        logic [NCORE-1:0] others;
        assign others = src_i & ~(NCORE'(1) << j);
        assign nxt[j] = accept_i[j] & (|others);

        AST_FAN_NOT_SELF: assert property (@(posedge clk) disable iff (rst)
            out_o[j] |-> $past(|(src_i & ~(NCORE'(1) << j)))); // R5
    end

    always_ff @(posedge clk) begin
        if (rst) out_o <= '0;
        else     out_o <= nxt;
    end

endmodule

// File: rtl/dxt_stall_path.sv
module dxt_stall_path #(
    parameter int NCORE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCORE-1:0] dbg_i,
    input  logic [NCORE-1:0] rsi_v,
    input  logic [NCORE-1:0] dmo_v,
    output logic [NCORE-1:0] stall_o
);

    logic [NCORE-1:0] drivers;
    assign drivers = dbg_i & dmo_v;

    for (genvar j = 0; j < NCORE; j++) begin : g_dst
        logic [NCORE-1:0] others;
        assign others     = drivers & ~(NCORE'(1) << j);
        assign stall_o[j] = rsi_v[j] & ~dbg_i[j] & (|others);

        AST_STALL_LIFT_IN_DEBUG: assert property (@(posedge clk) disable iff (rst)
            dbg_i[j] |-> !stall_o[j]); // R9
    end

endmodule

// File: rtl/dxt_xtrig_net.sv
module dxt_xtrig_net
    import dxt_pkg::*;
#(
    parameter  int NCORE = 4,
    localparam int CW    = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_en,
    input  logic [CW-1:0]    cfg_wr_core,
    input  logic [1:0]       cfg_wr_op,
    input  logic [3:0]       cfg_wr_data,
    input  logic [CW-1:0]    cfg_rd_core,
    output logic [3:0]       cfg_rd_data,
    input  logic [NCORE-1:0] core_dbg_i,
    input  logic [NCORE-1:0] core_trig_i,
    output logic [NCORE-1:0] core_brk_o,
    output logic [NCORE-1:0] core_stall_o,
    output logic [NCORE-1:0] core_trig_o
);

    logic [NCORE-1:0] bi_v, bo_v, rsi_v, dmo_v;
    logic [NCORE-1:0] dbg_q;
    logic [NCORE-1:0] brk_src, brk_acc, trc_src;

    dxt_cfg_regs #(.NCORE(NCORE)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_core (cfg_wr_core),
        .wr_op   (dxt_op_e'(cfg_wr_op)),
        .wr_data (cfg_wr_data),
        .rd_core (cfg_rd_core),
        .rd_data (cfg_rd_data),
        .bi_v    (bi_v),
        .bo_v    (bo_v),
        .rsi_v   (rsi_v),
        .dmo_v   (dmo_v)
    );

    // debug entry detector: only the rising edge of debug mode breaks others
    always_ff @(posedge clk) begin
        if (rst) dbg_q <= '0;
        else     dbg_q <= core_dbg_i;
    end

    assign brk_src = core_dbg_i & ~dbg_q & bo_v;
    assign brk_acc = bi_v & ~core_dbg_i;
    assign trc_src = core_trig_i & bo_v;

    dxt_fan #(.NCORE(NCORE)) u_brk_fan (
        .clk      (clk),
        .rst      (rst),
        .src_i    (brk_src),
        .accept_i (brk_acc),
        .out_o    (core_brk_o)
    );

    dxt_fan #(.NCORE(NCORE)) u_trc_fan (
        .clk      (clk),
        .rst      (rst),
        .src_i    (trc_src),
        .accept_i (bi_v),
        .out_o    (core_trig_o)
    );

    dxt_stall_path #(.NCORE(NCORE)) u_stall (
        .clk     (clk),
        .rst     (rst),
        .dbg_i   (core_dbg_i),
        .rsi_v   (rsi_v),
        .dmo_v   (dmo_v),
        .stall_o (core_stall_o)
    );

    for (genvar j = 0; j < NCORE; j++) begin : g_chk
        AST_BRK_ONLY_OUT_OF_DEBUG: assert property (@(posedge clk) disable iff (rst)
            core_brk_o[j] |-> $past(!core_dbg_i[j])); // R6
        AST_BRK_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
            core_brk_o[j] |-> $past(bi_v[j])); // R4
    end

    AST_BRK_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (core_brk_o != '0) |-> $past(|(core_dbg_i & ~dbg_q))); // R7
    AST_TRIG_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (core_stall_o != '0) |-> (core_dbg_i != '0)); // R11
    AST_TRIG_FROM_TRIG: assert property (@(posedge clk) disable iff (rst)
        (core_trig_o != '0) |-> $past(core_trig_i != '0)); // R10

endmodule

// File: tb/tb_dxt_xtrig_net.sv
`timescale 1ns/1ps
module tb_dxt_xtrig_net;

    localparam int N  = 4;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_wr_en;
    logic [CW-1:0] cfg_wr_core;
    logic [1:0]    cfg_wr_op;
    logic [3:0]    cfg_wr_data;
    logic [CW-1:0] cfg_rd_core;
    logic [3:0]    cfg_rd_data;
    logic [N-1:0]  core_dbg_i, core_trig_i;
    logic [N-1:0]  core_brk_o, core_stall_o, core_trig_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    dxt_xtrig_net #(.NCORE(N)) dut (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_core(cfg_wr_core), .cfg_wr_op(cfg_wr_op),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_core(cfg_rd_core), .cfg_rd_data(cfg_rd_data),
        .core_dbg_i(core_dbg_i), .core_trig_i(core_trig_i),
        .core_brk_o(core_brk_o), .core_stall_o(core_stall_o), .core_trig_o(core_trig_o)
    );

    // bench model of the enables and the previous debug level
    logic [3:0]   m_cfg [N];
    logic [N-1:0] m_prev;

    function automatic logic [3:0] f_op(input logic [1:0] op, input logic [3:0] d);
        case (op)
            2'd0:    return d;
            2'd1:    return 4'b0000;
            2'd2:    return 4'b0011;
            default: return 4'b1100;
        endcase
    endfunction

    function automatic logic [N-1:0] f_brk(input logic [N-1:0] dbg, input logic [N-1:0] prev);
        logic [N-1:0] r = '0;
        for (int j = 0; j < N; j++) begin
            bit hit = 0;
            for (int i = 0; i < N; i++)
                if (i != j && m_cfg[i][1] && dbg[i] && !prev[i]) hit = 1;
            r[j] = hit && m_cfg[j][0] && !dbg[j];
        end
        return r;
    endfunction

    function automatic logic [N-1:0] f_trc(input logic [N-1:0] trg);
        logic [N-1:0] r = '0;
        for (int j = 0; j < N; j++) begin
            bit hit = 0;
            for (int i = 0; i < N; i++)
                if (i != j && m_cfg[i][1] && trg[i]) hit = 1;
            r[j] = hit && m_cfg[j][0];
        end
        return r;
    endfunction

    function automatic logic [N-1:0] f_stall(input logic [N-1:0] dbg);
        logic [N-1:0] r = '0;
        for (int j = 0; j < N; j++) begin
            bit hit = 0;
            for (int i = 0; i < N; i++)
                if (i != j && m_cfg[i][3] && dbg[i]) hit = 1;
            r[j] = hit && m_cfg[j][2] && !dbg[j];
        end
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // inputs are set just after a negedge; stall and readback checked before the edge,
    // break and trace checked just after it
    task automatic cycle(input string rb, input string rs, input string rt);
        logic [N-1:0] e_brk, e_trc;
        #1;
        chk(rs, "stall", 8'(core_stall_o), 8'(f_stall(core_dbg_i)));
        chk("R2", "readback", 8'(cfg_rd_data), 8'(m_cfg[cfg_rd_core]));
        e_brk = f_brk(core_dbg_i, m_prev);
        e_trc = f_trc(core_trig_i);
        @(posedge clk);
        if (cfg_wr_en) m_cfg[cfg_wr_core] = f_op(cfg_wr_op, cfg_wr_data);
        m_prev = core_dbg_i;
        #1;
        chk(rb, "brk", 8'(core_brk_o), 8'(e_brk));
        chk(rt, "trig", 8'(core_trig_o), 8'(e_trc));
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic wr(input int core, input logic [1:0] op, input logic [3:0] d, input string req);
        cfg_wr_en = 1'b1; cfg_wr_core = CW'(core); cfg_wr_op = op; cfg_wr_data = d;
        cycle("R4", "R8", "R10");
        cfg_rd_core = CW'(core);
        #1;
        chk(req, "written value", 8'(cfg_rd_data), 8'(f_op(op, d)));
        chk(req, "model value", 8'(cfg_rd_data), 8'(m_cfg[core]));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        rst = 1'b1; cfg_wr_en = 0; cfg_wr_core = 0; cfg_wr_op = 0; cfg_wr_data = 0;
        cfg_rd_core = 0; core_dbg_i = '0; core_trig_i = '0;
        for (int k = 0; k < N; k++) m_cfg[k] = '0;
        m_prev = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", "brk", 8'(core_brk_o), 8'h0);
        chk("R1", "stall", 8'(core_stall_o), 8'h0);
        chk("R1", "trig", 8'(core_trig_o), 8'h0);
        for (int k = 0; k < N; k++) begin
            cfg_rd_core = CW'(k); #0.1;
            chk("R1", "cfg", 8'(cfg_rd_data), 8'h0);
        end
        @(negedge clk);

        // R2 raw write, R3 presets ignore data
        wr(1, 2'd0, 4'b1010, "R2");
        wr(1, 2'd1, 4'hF, "R3");
        wr(0, 2'd2, 4'hF, "R3");
        wr(2, 2'd3, 4'h0, "R3");
        chk("R3", "brkchain", 8'(m_cfg[0]), 8'b0011);
        chk("R3", "runstall", 8'(m_cfg[2]), 8'b1100);
        for (int k = 0; k < N; k++) wr(k, 2'd2, 4'h0, "R3");

        // R4/R5 core0 enters debug: others pulse, core0 not
        core_dbg_i = 4'b0001; cycle("R4", "R8", "R10");
        chk("R5", "own brk", 8'(core_brk_o[0]), 8'h0);
        chk("R4", "pulse", 8'(core_brk_o), 8'(4'b1110));
        cycle("R4", "R8", "R10");
        chk("R4", "pulse end", 8'(core_brk_o), 8'h0);
        // R7 release not propagated
        core_dbg_i = 4'b0000; cycle("R7", "R8", "R10");
        chk("R7", "release", 8'(core_brk_o), 8'h0);
        // R6 core in debug ignores break
        core_dbg_i = 4'b0100; cycle("R6", "R8", "R10");
        core_dbg_i = 4'b0000; cycle("R6", "R8", "R10");
        core_dbg_i = 4'b1100; cycle("R6", "R8", "R10");
        chk("R6", "masked", 8'(core_brk_o), 8'(4'b0011));
        core_dbg_i = 4'b0000; cycle("R7", "R8", "R10");

        // R10/R11 trace routing never halts
        for (int k = 0; k < N; k++) wr(k, 2'd0, 4'b1111, "R2");
        core_trig_i = 4'b0001; cycle("R11", "R11", "R10");
        chk("R10", "trig", 8'(core_trig_o), 8'(4'b1110));
        chk("R11", "brk", 8'(core_brk_o), 8'h0);
        core_trig_i = 4'b1111; #1;
        chk("R11", "stall", 8'(core_stall_o), 8'h0);
        cycle("R11", "R11", "R10");
        chk("R11", "brk all", 8'(core_brk_o), 8'h0);
        core_trig_i = 4'b0000; cycle("R11", "R11", "R10");

        // R8/R9 stall and its lift
        core_dbg_i = 4'b0001; #1;
        chk("R8", "stall", 8'(core_stall_o), 8'(4'b1110));
        cycle("R4", "R8", "R10");
        core_dbg_i = 4'b0011; #1;
        chk("R9", "lift", 8'(core_stall_o), 8'(4'b1100));
        cycle("R6", "R9", "R10");
        core_dbg_i = 4'b0000; #1;
        chk("R8", "resume", 8'(core_stall_o), 8'h0);
        cycle("R7", "R8", "R10");

        // R12 isolate then restore
        for (int k = 0; k < N; k++) wr(k, 2'd2, 4'h0, "R3");
        wr(0, 2'd1, 4'h0, "R12");
        core_dbg_i = 4'b0001; cycle("R12", "R8", "R10");
        chk("R12", "isolated", 8'(core_brk_o), 8'h0);
        core_dbg_i = 4'b0000; cycle("R12", "R8", "R10");
        wr(0, 2'd0, 4'b0011, "R12");
        core_dbg_i = 4'b0001; cycle("R12", "R8", "R10");
        chk("R12", "restored", 8'(core_brk_o), 8'(4'b1110));
        core_dbg_i = 4'b0000; cycle("R7", "R8", "R10");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            if (($urandom % 10) == 0) begin
                cfg_wr_en = 1'b1; cfg_wr_core = CW'($urandom);
                cfg_wr_op = 2'($urandom); cfg_wr_data = 4'($urandom);
            end
            cfg_rd_core = CW'($urandom);
            for (int k = 0; k < N; k++)
                if (($urandom % 6) == 0) core_dbg_i[k] = ~core_dbg_i[k];
            core_trig_i = N'($urandom) & N'($urandom);
            cycle("R4", "R8", "R10");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule